// File: doc/BRIEF.md
# Register-Mapped I2C Master Controller

This block is the processor-facing half of an I2C master. Software sees five byte-wide registers through a simple request/done register port: own address, clock divider, control, status and data. The block turns register activity into byte-level requests toward a separate bus engine, which handles the wire timing. The four requests are START (address byte), SEND (data byte), RECV (fetch a byte) and STOP. The block tracks whether a transfer is open, raises an interrupt flag with its matching output line, and performs a soft reset when software clears the enable bit.

In master mode, the first data-register write after the bus is claimed is taken as the address byte. Bits 7:1 are the 7-bit target and bit 0 is the direction, where 1 means read. Each later write sends one data byte. In receive mode, a data-register read returns the byte fetched by the previous read and then fetches the next one. The first read is therefore a dummy read. Each register access stalls until any bus request it causes has been answered, so every register operation completes as one atomic step.

Register offsets are: own address 0, divider 1, control 2, status 3, data 4. Control bits are: enable 7, interrupt enable 6, master 5, transmit 4, ack-control 3, repeated start 2. Status bits are: transfer-done 7 (always 1), bus busy 5, arbitration lost 4, interrupt flag 1, received NACK 0. Bus opcodes are START=0, SEND=1, RECV=2 and STOP=3.

Top module: `i2cm_ctrl`

## Requirements
- R1: After hard reset, control, own address, divider and data read 0x00, status reads 0x81, and `irq_o` is 0.
- R2: Writes are masked as follows: own address with 0xFE, divider with 0x3F, control with 0xFC. Offsets 5 to 7 read 0x00 and ignore writes.
- R3: A normal control write with master bit 5 set sets status bit 5 (busy). A control write with bit 5 clear clears busy and, if a transfer is open, issues one STOP.
- R4: A data write while control bit 7 (enable) is 0 issues no bus request and changes no readable state.
- R5: In master mode with no transfer open, a data write issues START with the byte. If the engine accepts it, the transfer opens, status bit 0 clears and an interrupt is raised. If the engine rejects it, status bit 0 sets and the transfer stays closed, so the next data write is again a START.
- R6: A data write while a transfer is open issues SEND. An ACK clears status bit 0 and raises an interrupt. A NACK sets status bit 0, raises no interrupt, issues a STOP and closes the transfer.
- R7: A data read in master mode with a transfer open and control bit 4 clear returns the previously held byte and issues RECV. A successful fetch stores the new byte and raises an interrupt.
- R8: In master mode, a failed RECV stores 0xFF and raises no interrupt. A data read with no open transfer, or with bit 4 set, issues no request and also stores 0xFF. The 0xFF is returned by the next data read.
- R9: Raising an interrupt sets status bit 1 and drives `irq_o` high only when control bits 7 and 6 are both set.
- R10: A status write of 0 to bit 1 clears the flag and `irq_o`, and a write of 0 to bit 4 clears arbitration lost. Writing 1 to any bit changes nothing, and no other status bit is writable.
- R11: A control write with master and repeated-start bit 2 set, while a transfer is open, issues STOP and closes the transfer. Bit 2 then reads back 0.
- R12: A control write that clears bit 7 while bit 7 is set performs a soft reset. Every register except own address returns to its reset value, an open transfer is ended with STOP, and the written value is not stored.
- R13: `reg_done` is a one-cycle pulse per register access. While `bus_valid` waits for `bus_ready`, the request stays asserted with a stable opcode and byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | Register access request, held until `reg_done` |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_ofs | input | OFS_W | Register offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid with `reg_done` |
| reg_done | output | 1 | One-cycle completion pulse |
| irq_o | output | 1 | Interrupt line, follows status flag |
| bus_valid | output | 1 | Bus engine request valid |
| bus_ready | input | 1 | Bus engine accepts request |
| bus_op | output | 2 | Request opcode: 0 START, 1 SEND, 2 RECV, 3 STOP |
| bus_wdata | output | DATA_W | Address byte for START, data byte for SEND |
| bus_rsp_valid | input | 1 | Response pulse from the bus engine |
| bus_rsp_ack | input | 1 | 1 = acknowledged / success |
| bus_rsp_data | input | DATA_W | Byte fetched by RECV |

## Verification
The bench first targets the address phase, covering a rejected address and an accepted one. A design that marked the transfer open after a rejection would issue SEND instead of a fresh START on the next write. It then exercises the one-behind receive path, including a failed fetch whose response carries a non-0xFF byte. A design that returned the fresh byte, or latched the failing data, would read back the wrong value. Repeated start, master-bit clear, NACK on send and soft reset are each checked by counting STOP requests and reading back control, status and divider. An extra or missing STOP, a stored repeated-start bit, or a lost own address would show up there. Interrupt gating with interrupt enable off, and write-one-no-effect on status, are also checked at `irq_o`.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_SEND  = 2'd1,
      OP_RECV  = 2'd2,
      OP_STOP  = 2'd3
   } bus_op_e;

   localparam int OFS_OWN  = 0;
   localparam int OFS_DIV  = 1;
   localparam int OFS_CTRL = 2;
   localparam int OFS_STAT = 3;
   localparam int OFS_DATA = 4;

   localparam int CB_EN   = 7;
   localparam int CB_IEN  = 6;
   localparam int CB_MS   = 5;
   localparam int CB_TX   = 4;
   localparam int CB_RSTA = 2;

   localparam int SB_BUSY = 5;
   localparam int SB_ARB  = 4;
   localparam int SB_IRQ  = 1;
   localparam int SB_NACK = 0;

   localparam logic [7:0] CTRL_WMASK = 8'hFC;
   localparam logic [7:0] STAT_RESET = 8'h81;
endpackage

// File: rtl/i2cm_cfg_regs.sv
module i2cm_cfg_regs #(
   parameter int DATA_W = 8,
   parameter int NREG   = 2,
   parameter logic [NREG*DATA_W-1:0] WMASK = '1,
   parameter logic [NREG-1:0] KEEP_SOFT = '0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   soft_rst,
   input  logic [NREG-1:0]        wr,
   input  logic [DATA_W-1:0]      wdata,
   output logic [NREG*DATA_W-1:0] q
);
   initial begin
      assert (NREG >= 1) else $error("NREG must be at least 1");
   end

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DATA_W-1:0] r;
      if (KEEP_SOFT[g]) begin : g_keep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     r <= '0;
            else if (wr[g]) r <= wdata & WMASK[g*DATA_W +: DATA_W];
         end
      end else begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        r <= '0;
            else if (soft_rst) r <= '0;
            else if (wr[g])    r <= wdata & WMASK[g*DATA_W +: DATA_W];
         end
      end
      assign q[g*DATA_W +: DATA_W] = r;
   end
endmodule

// File: rtl/i2cm_rdmux.sv
module i2cm_rdmux
   import i2cm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OFS_W  = 3
) (
   input  logic [OFS_W-1:0]  ofs,
   input  logic [DATA_W-1:0] own,
   input  logic [DATA_W-1:0] div,
   input  logic [DATA_W-1:0] ctrl,
   input  logic [DATA_W-1:0] stat,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] val
);
   always_comb begin
      val = '0;
      case (ofs)
         OFS_W'(OFS_OWN):  val = own;
         OFS_W'(OFS_DIV):  val = div;
         OFS_W'(OFS_CTRL): val = ctrl;
         OFS_W'(OFS_STAT): val = stat;
         OFS_W'(OFS_DATA): val = data;
         default:          val = '0;
      endcase
   end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
   import i2cm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OFS_W  = 3,
   parameter logic [DATA_W-1:0] FILL = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_req,
   input  logic              reg_we,
   input  logic [OFS_W-1:0]  reg_ofs,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] rd_val,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              reg_done,
   output logic              acc_o,
   output logic              soft_rst_o,
   output logic [DATA_W-1:0] ctrl_o,
   output logic [DATA_W-1:0] stat_o,
   output logic [DATA_W-1:0] data_o,
   output logic              irq_o,
   output logic              bus_valid,
   input  logic              bus_ready,
   output logic [1:0]        bus_op,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rsp_valid,
   input  logic              bus_rsp_ack,
   input  logic [DATA_W-1:0] bus_rsp_data
);
   typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_e;

   st_e               st_q;
   bus_op_e           op_q, acc_op;
   logic [DATA_W-1:0] ctrl_q, stat_q, data_q, rdata_q, bwd_q;
   logic [DATA_W-1:0] ctrl_new, ctrl_keep;
   logic              open_q, done_q, acc_bus;
   logic              wr_ctrl, wr_stat, wr_data, rd_data;
   logic              soft_hit, stop_ms, stop_rs, raise_ok, master, txmode, rd_fill;

   assign acc_o    = (st_q == S_IDLE) && reg_req && !done_q;
   assign wr_ctrl  = acc_o && reg_we  && (reg_ofs == OFS_W'(OFS_CTRL));
   assign wr_stat  = acc_o && reg_we  && (reg_ofs == OFS_W'(OFS_STAT));
   assign wr_data  = acc_o && reg_we  && (reg_ofs == OFS_W'(OFS_DATA));
   assign rd_data  = acc_o && !reg_we && (reg_ofs == OFS_W'(OFS_DATA));
   assign master   = ctrl_q[CB_MS];
   assign txmode   = ctrl_q[CB_TX];
   assign raise_ok = ctrl_q[CB_EN] && ctrl_q[CB_IEN];
   assign soft_hit = wr_ctrl && ctrl_q[CB_EN] && !reg_wdata[CB_EN];
   assign soft_rst_o = soft_hit;

   always_comb begin
      ctrl_new  = reg_wdata & CTRL_WMASK;
      stop_ms   = !ctrl_new[CB_MS] && open_q;
      stop_rs   = ctrl_new[CB_MS] && ctrl_new[CB_RSTA] && open_q;
      ctrl_keep = ctrl_new;
      ctrl_keep[CB_RSTA] = ctrl_new[CB_RSTA] && !stop_rs;
      rd_fill   = rd_data && master && !(open_q && !txmode);
      acc_bus   = 1'b0;
      acc_op    = OP_STOP;
      if (soft_hit) begin
         acc_bus = open_q;
      end else if (wr_ctrl) begin
         acc_bus = stop_ms || stop_rs;
      end else if (wr_data && ctrl_q[CB_EN] && master) begin
         acc_bus = 1'b1;
         acc_op  = open_q ? OP_SEND : OP_START;
      end else if (rd_data && master && open_q && !txmode) begin
         acc_bus = 1'b1;
         acc_op  = OP_RECV;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         op_q    <= OP_STOP;
         ctrl_q  <= '0;
         stat_q  <= STAT_RESET;
         data_q  <= '0;
         rdata_q <= '0;
         bwd_q   <= '0;
         open_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            S_IDLE: begin
               if (acc_o) begin
                  rdata_q <= rd_val;
                  if (acc_bus) begin
                     st_q  <= S_REQ;
                     op_q  <= acc_op;
                     bwd_q <= reg_wdata;
                  end else begin
                     done_q <= 1'b1;
                  end
                  if (soft_hit) begin
                     ctrl_q <= '0;
                     stat_q <= STAT_RESET;
                     data_q <= '0;
                     open_q <= 1'b0;
                  end else if (wr_ctrl) begin
                     ctrl_q <= ctrl_keep;
                     stat_q[SB_BUSY] <= ctrl_new[CB_MS];
                     if (stop_ms || stop_rs) open_q <= 1'b0;
                  end else if (wr_stat) begin
                     stat_q[SB_IRQ] <= stat_q[SB_IRQ] && reg_wdata[SB_IRQ];
                     stat_q[SB_ARB] <= stat_q[SB_ARB] && reg_wdata[SB_ARB];
                  end else if (rd_fill) begin
                     data_q <= FILL;
                  end
               end
            end
            S_REQ: begin
               if (bus_ready) st_q <= S_WAIT;
            end
            S_WAIT: begin
               if (bus_rsp_valid) begin
                  st_q   <= S_IDLE;
                  done_q <= 1'b1;
                  case (op_q)
                     OP_START: begin
                        if (bus_rsp_ack) begin
                           open_q <= 1'b1;
                           stat_q[SB_NACK] <= 1'b0;
                           if (raise_ok) stat_q[SB_IRQ] <= 1'b1;
                        end else begin
                           stat_q[SB_NACK] <= 1'b1;
                        end
                     end
                     OP_SEND: begin
                        if (bus_rsp_ack) begin
                           stat_q[SB_NACK] <= 1'b0;
                           if (raise_ok) stat_q[SB_IRQ] <= 1'b1;
                        end else begin
                           stat_q[SB_NACK] <= 1'b1;
                           open_q <= 1'b0;
                           op_q   <= OP_STOP;
                           st_q   <= S_REQ;
                           done_q <= 1'b0;
                        end
                     end
                     OP_RECV: begin
                        data_q <= bus_rsp_ack ? bus_rsp_data : FILL;
                        if (bus_rsp_ack && raise_ok) stat_q[SB_IRQ] <= 1'b1;
                     end
                     default: ;
                  endcase
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign reg_rdata = rdata_q;
   assign reg_done  = done_q;
   assign ctrl_o    = ctrl_q;
   assign stat_o    = stat_q;
   assign data_o    = data_q;
   assign irq_o     = stat_q[SB_IRQ];
   assign bus_valid = (st_q == S_REQ);
   assign bus_op    = op_q;
   assign bus_wdata = bwd_q;

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_ready |=> bus_valid && $stable(bus_op) && $stable(bus_wdata)); // R13
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_done |=> !reg_done); // R13
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(ctrl_q[CB_EN] && ctrl_q[CB_IEN])); // R9
   AST_NO_BUS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && (op_q == OP_START || op_q == OP_SEND) |-> ctrl_q[CB_EN]); // R4
   AST_NACK_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_WAIT) && bus_rsp_valid && (op_q == OP_SEND) && !bus_rsp_ack
      |=> !open_q && stat_q[SB_NACK] && bus_valid && (op_q == OP_STOP)); // R6
   AST_STOP_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_WAIT) && bus_rsp_valid && (op_q == OP_STOP) |-> !open_q); // R11
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
   import i2cm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OFS_W  = 3,
   parameter logic [DATA_W-1:0] OWN_MASK = 8'hFE,
   parameter logic [DATA_W-1:0] DIV_MASK = 8'h3F,
   parameter logic [DATA_W-1:0] RX_FILL  = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_req,
   input  logic              reg_we,
   input  logic [OFS_W-1:0]  reg_ofs,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              reg_done,
   output logic              irq_o,
   output logic              bus_valid,
   input  logic              bus_ready,
   output logic [1:0]        bus_op,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rsp_valid,
   input  logic              bus_rsp_ack,
   input  logic [DATA_W-1:0] bus_rsp_data
);
   localparam int NCFG = 2;

   initial begin
      assert (DATA_W == 8) else $error("DATA_W must be 8 for byte-wide registers");
      assert (OFS_W >= 3)  else $error("OFS_W must cover five register offsets");
   end

   logic [NCFG*DATA_W-1:0] cfg_q;
   logic [NCFG-1:0]        cfg_wr;
   logic [DATA_W-1:0]      ctrl_v, stat_v, data_v, rd_val;
   logic                   acc, soft_rst;

   for (genvar g = 0; g < NCFG; g++) begin : g_cfgwr
      assign cfg_wr[g] = acc && reg_we && (reg_ofs == OFS_W'(g));
   end

   i2cm_cfg_regs #(
      .DATA_W(DATA_W), .NREG(NCFG),
      .WMASK({DIV_MASK, OWN_MASK}),
      .KEEP_SOFT(2'b01)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr(cfg_wr), .wdata(reg_wdata), .q(cfg_q)
   );

   i2cm_rdmux #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_mux (
      .ofs(reg_ofs),
      .own(cfg_q[OFS_OWN*DATA_W +: DATA_W]),
      .div(cfg_q[OFS_DIV*DATA_W +: DATA_W]),
      .ctrl(ctrl_v), .stat(stat_v), .data(data_v), .val(rd_val)
   );

   i2cm_engine #(.DATA_W(DATA_W), .OFS_W(OFS_W), .FILL(RX_FILL)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .reg_req(reg_req), .reg_we(reg_we), .reg_ofs(reg_ofs), .reg_wdata(reg_wdata),
      .rd_val(rd_val), .reg_rdata(reg_rdata), .reg_done(reg_done),
      .acc_o(acc), .soft_rst_o(soft_rst),
      .ctrl_o(ctrl_v), .stat_o(stat_v), .data_o(data_v), .irq_o(irq_o),
      .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_op(bus_op), .bus_wdata(bus_wdata),
      .bus_rsp_valid(bus_rsp_valid), .bus_rsp_ack(bus_rsp_ack), .bus_rsp_data(bus_rsp_data)
   );
endmodule

// File: tb/i2cm_ctrl_tb_top.sv
module i2cm_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_req = 1'b0, reg_we = 1'b0;
   logic [2:0] reg_ofs = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       reg_done, irq_o, bus_valid, bus_ready;
   logic [1:0] bus_op;
   logic [7:0] bus_wdata;
   logic       rsp_v, rsp_ack;
   logic [7:0] rsp_d;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   i2cm_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .reg_req(reg_req), .reg_we(reg_we), .reg_ofs(reg_ofs), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .reg_done(reg_done), .irq_o(irq_o),
      .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_op(bus_op), .bus_wdata(bus_wdata),
      .bus_rsp_valid(rsp_v), .bus_rsp_ack(rsp_ack), .bus_rsp_data(rsp_d)
   );

   // Bus engine model: accepts targets 0x50 and 0x51; SEND of 0xEE is NACKed;
   // RECV on 0x51 fails (with junk data 0x77), else returns 0x3C, 0x3D, ...
   logic       tick;
   logic [6:0] tgt;
   logic [1:0] last_op;
   int         op_cnt, stop_cnt, recv_n;
   assign bus_ready = tick;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick <= 1'b0; rsp_v <= 1'b0; rsp_ack <= 1'b0; rsp_d <= '0;
         tgt <= '0; last_op <= 2'd3; op_cnt <= 0; stop_cnt <= 0; recv_n <= 0;
      end else begin
         tick  <= ~tick;
         rsp_v <= 1'b0;
         if (bus_valid && bus_ready) begin
            rsp_v   <= 1'b1;
            rsp_d   <= 8'h00;
            last_op <= bus_op;
            op_cnt  <= op_cnt + 1;
            case (bus_op)
               2'd0: begin
                  tgt     <= bus_wdata[7:1];
                  rsp_ack <= (bus_wdata[7:1] == 7'h50) || (bus_wdata[7:1] == 7'h51);
               end
               2'd1: rsp_ack <= (bus_wdata != 8'hEE);
               2'd2: begin
                  if (tgt == 7'h51) begin
                     rsp_ack <= 1'b0; rsp_d <= 8'h77;
                  end else begin
                     rsp_ack <= 1'b1; rsp_d <= 8'h3C + 8'(recv_n); recv_n <= recv_n + 1;
                  end
               end
               default: begin rsp_ack <= 1'b1; stop_cnt <= stop_cnt + 1; end
            endcase
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic host(input logic we, input logic [2:0] a, input logic [7:0] d,
                       output logic [7:0] q);
      @(negedge clk);
      reg_req = 1'b1; reg_we = we; reg_ofs = a; reg_wdata = d;
      do @(negedge clk); while (!reg_done);
      q = reg_rdata;
      reg_req = 1'b0;
   endtask

   // vector: [23] we, [22:20] offset, [19:12] wdata, [11:4] expected read, [3:0] req
   localparam int NV = 64;
   localparam logic [23:0] VEC [NV] = '{
      {1'b0,3'd2,8'h00,8'h00,4'd1},  // R1 control
      {1'b0,3'd3,8'h00,8'h81,4'd1},  // R1 status
      {1'b0,3'd0,8'h00,8'h00,4'd1},  // R1 own
      {1'b0,3'd4,8'h00,8'h00,4'd1},  // R1 data
      {1'b1,3'd0,8'hFF,8'h00,4'd2},  // R2
      {1'b0,3'd0,8'h00,8'hFE,4'd2},
      {1'b1,3'd1,8'hFF,8'h00,4'd2},
      {1'b0,3'd1,8'h00,8'h3F,4'd2},
      {1'b1,3'd2,8'hFF,8'h00,4'd2},
      {1'b0,3'd2,8'h00,8'hFC,4'd2},
      {1'b0,3'd3,8'h00,8'hA1,4'd3},  // R3 busy
      {1'b1,3'd2,8'h00,8'h00,4'd12}, // R12 soft reset
      {1'b0,3'd1,8'h00,8'h00,4'd12},
      {1'b0,3'd0,8'h00,8'hFE,4'd12},
      {1'b0,3'd3,8'h00,8'h81,4'd12},
      {1'b0,3'd2,8'h00,8'h00,4'd12},
      {1'b1,3'd4,8'h55,8'h00,4'd4},  // R4 disabled write
      {1'b0,3'd4,8'h00,8'h00,4'd4},
      {1'b1,3'd2,8'hF0,8'h00,4'd3},
      {1'b0,3'd3,8'h00,8'hA1,4'd3},
      {1'b1,3'd4,8'hA0,8'h00,4'd5},  // R5 accepted
      {1'b0,3'd3,8'h00,8'hA2,4'd5},
      {1'b1,3'd3,8'h00,8'h00,4'd10}, // R10
      {1'b0,3'd3,8'h00,8'hA0,4'd10},
      {1'b1,3'd4,8'h12,8'h00,4'd6},  // R6 ack
      {1'b0,3'd3,8'h00,8'hA2,4'd6},
      {1'b1,3'd3,8'hFD,8'h00,4'd10},
      {1'b0,3'd3,8'h00,8'hA0,4'd10},
      {1'b1,3'd4,8'hEE,8'h00,4'd6},  // R6 nack
      {1'b0,3'd3,8'h00,8'hA1,4'd6},
      {1'b1,3'd4,8'hA0,8'h00,4'd5},
      {1'b1,3'd3,8'h00,8'h00,4'd10},
      {1'b1,3'd2,8'hE0,8'h00,4'd7},  // R7 receive
      {1'b0,3'd4,8'h00,8'h00,4'd7},
      {1'b0,3'd3,8'h00,8'hA2,4'd7},
      {1'b1,3'd3,8'h00,8'h00,4'd10},
      {1'b0,3'd4,8'h00,8'h3C,4'd7},
      {1'b1,3'd2,8'hE4,8'h00,4'd11}, // R11 repeated start
      {1'b1,3'd3,8'h00,8'h00,4'd10},
      {1'b0,3'd2,8'h00,8'hE0,4'd11},
      {1'b0,3'd4,8'h00,8'h3D,4'd8},  // R8 no open transfer
      {1'b0,3'd4,8'h00,8'hFF,4'd8},
      {1'b0,3'd3,8'h00,8'hA0,4'd8},
      {1'b1,3'd4,8'hA3,8'h00,4'd5},
      {1'b0,3'd3,8'h00,8'hA2,4'd5},
      {1'b1,3'd3,8'h00,8'h00,4'd10},
      {1'b0,3'd4,8'h00,8'hFF,4'd8},  // R8 failed fetch
      {1'b0,3'd3,8'h00,8'hA0,4'd8},
      {1'b0,3'd4,8'h00,8'hFF,4'd8},
      {1'b1,3'd2,8'hC0,8'h00,4'd3},  // R3 master clear
      {1'b0,3'd3,8'h00,8'h80,4'd3},
      {1'b1,3'd2,8'hF0,8'h00,4'd5},
      {1'b1,3'd4,8'h20,8'h00,4'd5},  // R5 rejected
      {1'b0,3'd3,8'h00,8'hA1,4'd5},
      {1'b1,3'd4,8'hA0,8'h00,4'd5},
      {1'b1,3'd3,8'h00,8'h00,4'd10},
      {1'b0,3'd4,8'h00,8'hFF,4'd8},  // R8 transmit mode read
      {1'b0,3'd3,8'h00,8'hA0,4'd8},
      {1'b1,3'd2,8'h00,8'h00,4'd12},
      {1'b1,3'd2,8'hB0,8'h00,4'd9},  // R9 interrupt enable off
      {1'b1,3'd4,8'hA0,8'h00,4'd9},
      {1'b0,3'd3,8'h00,8'hA0,4'd9},
      {1'b1,3'd5,8'hAA,8'h00,4'd2},  // R2 unmapped
      {1'b0,3'd5,8'h00,8'h00,4'd2}
   };

   initial begin : main
      logic [7:0] q;
      int n, s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 irq after reset", int'(irq_o), 0);
      for (int i = 0; i < NV; i++) begin
         host(VEC[i][23], VEC[i][22:20], VEC[i][19:12], q);
         if (!VEC[i][23])
            chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), int'(q), int'(VEC[i][11:4]));
      end
      // directed: soft reset ends open transfer, then disabled write is ignored
      s = stop_cnt;
      host(1'b1, 3'd2, 8'h00, q);
      chk("R12 soft reset stop", stop_cnt, s + 1);
      host(1'b0, 3'd2, 8'h00, q);
      chk("R12 control not stored", int'(q), 0);
      n = op_cnt;
      host(1'b1, 3'd4, 8'hA0, q);
      chk("R4 no bus request when disabled", op_cnt, n);
      // rejected address leaves transfer closed
      host(1'b1, 3'd2, 8'hF0, q);
      n = op_cnt;
      host(1'b1, 3'd4, 8'h20, q);
      host(1'b1, 3'd4, 8'hA0, q);
      chk("R5 two requests", op_cnt, n + 2);
      chk("R5 retry is START", int'(last_op), 0);
      chk("R9 irq raised", int'(irq_o), 1);
      host(1'b1, 3'd3, 8'h02, q);
      chk("R10 write one keeps irq", int'(irq_o), 1);
      host(1'b1, 3'd3, 8'h00, q);
      chk("R10 write zero clears irq", int'(irq_o), 0);
      // nack on send
      s = stop_cnt;
      host(1'b1, 3'd4, 8'hEE, q);
      chk("R6 nack stop", stop_cnt, s + 1);
      chk("R6 last op STOP", int'(last_op), 3);
      chk("R6 no irq on nack", int'(irq_o), 0);
      host(1'b1, 3'd4, 8'hA0, q);
      chk("R6 next write is START", int'(last_op), 0);
      // master clear ends transfer
      s = stop_cnt;
      host(1'b1, 3'd2, 8'hC0, q);
      chk("R3 master clear stop", stop_cnt, s + 1);
      @(negedge clk);
      chk("R13 done is single cycle", int'(reg_done), 0);
      // transmit-mode read issues nothing; receive-mode read issues RECV
      host(1'b1, 3'd2, 8'hF0, q);
      host(1'b1, 3'd4, 8'hA0, q);
      n = op_cnt;
      host(1'b0, 3'd4, 8'h00, q);
      chk("R8 no RECV in transmit mode", op_cnt, n);
      host(1'b1, 3'd2, 8'hE0, q);
      n = op_cnt;
      host(1'b0, 3'd4, 8'h00, q);
      chk("R7 one RECV", op_cnt, n + 1);
      chk("R7 last op RECV", int'(last_op), 2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule